// File: doc/BRIEF.md
# Token-Ring Round-Robin Arbiter

The block shares one resource among a fixed number of requesters, with a ring of identical cells and a single token that moves around it. Each clock, the token stands at exactly one cell. That cell starts an arbitration scan. A cell whose scan enable is high either takes the grant, if its own request is high, or passes the enable on to the next cell in ring order within the same cycle. The token moves forward by one cell on every clock, whether or not any requester is active. As a result, priority rotates at a steady pace and no requester can be held off for long.

The ring is built without a combinational loop. The scan runs along an unrolled chain of twice the ring length. Only the first half of that chain can receive the token, so a scan from any holder covers every cell once and then stops. The grant from the scan is registered before it reaches the output.

Top module: `token_ring_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, the grant vector is all zero. The token starts at cell 0, so the first clock after reset with every request high grants cell 0 (grant = 1 << 0).
- R2: The grant vector never has more than one bit set.
- R3: A clock edge at which the request vector is all zero produces an all-zero grant for the next cycle.
- R4: If the cell holding the token at a clock edge is requesting, that cell is the one granted after the edge.
- R5: If the token holder at index k is not requesting, the grant goes to the first requesting cell in the order k+1, k+2, ..., wrapping from NUM_CELLS-1 to 0.
- R6: The token moves from cell i to cell (i+1) mod NUM_CELLS at every clock edge after reset, including edges where nothing is requested.
- R7: The grant is registered. The output during a cycle reflects the request vector and token position at the previous clock edge, and a change of request between edges does not change the grant.
- R8: A cell that requests without a break is granted within NUM_CELLS consecutive clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NUM_CELLS | Request vector, bit i belongs to cell i |
| grant | output | NUM_CELLS | Registered grant, one-hot or all zero |

## Verification
The bench steers the token to each ring position in turn and sends requests both at the holder and behind it. This catches a scan that starts at a fixed cell instead of the holder, and a scan that fails to wrap from the top index back to cell 0. Idle stretches check that the token keeps moving when nothing is requested; a token that stalls while idle would grant the wrong cell when requests return. All-ones requests check that each cell is granted exactly once per trip around the ring. A cell held on continuously, with the other requests changing around it, exposes starvation or a double grant. Changing the request between clock edges exposes a grant output that is not registered.

// File: rtl/tr_pkg.sv
package tr_pkg;
  typedef struct packed {
    logic go;
    logic ok;
    logic pass;
  } cell_out_t;
endpackage

// File: rtl/tr_token_ring.sv
module tr_token_ring #(
  parameter int unsigned NUM_CELLS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [NUM_CELLS-1:0] token
);
  logic [NUM_CELLS-1:0] tok_q;

  generate
    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_slot
      localparam int unsigned UPSTREAM = (i + NUM_CELLS - 1) % NUM_CELLS;
      always_ff @(posedge clk) begin
        if (rst) tok_q[i] <= (i == 0);
        else     tok_q[i] <= tok_q[UPSTREAM];
      end
    end
  endgenerate

  assign token = tok_q;

  // R6: exactly one cell holds the token at all times after reset
  a_r6_token_single: assert property (@(posedge clk) disable iff (rst)
    $countones(token) == 1);

  // R1: the token sits at cell 0 right after reset
  a_r1_token_home: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> token[0]);
endmodule

// File: rtl/tr_cell.sv
module tr_cell
  import tr_pkg::*;
(
  input  logic      req,
  input  logic      try_in,
  input  logic      tok_in,
  output cell_out_t o
);
  always_comb begin
    o.go   = try_in | tok_in;
    o.ok   = o.go & req;
    o.pass = o.go & ~req;
  end
endmodule

// File: rtl/tr_scan_chain.sv
module tr_scan_chain
  import tr_pkg::*;
#(
  parameter int unsigned NUM_CELLS = 4
) (
  input  logic [NUM_CELLS-1:0] req,
  input  logic [NUM_CELLS-1:0] token,
  output logic [NUM_CELLS-1:0] grant
);
  localparam int unsigned CHAIN_LEN = 2 * NUM_CELLS;

  cell_out_t stage [CHAIN_LEN];

  generate
    for (genvar j = 0; j < CHAIN_LEN; j++) begin : g_stage
      localparam int unsigned IDX = j % NUM_CELLS;
      logic try_w;
      logic tok_w;
      if (j == 0) begin : g_head
        assign try_w = 1'b0;
      end else begin : g_link
        assign try_w = stage[j-1].pass;
      end
      if (j < NUM_CELLS) begin : g_first
        assign tok_w = token[IDX];
      end else begin : g_second
        assign tok_w = 1'b0;
      end
      tr_cell u_cell (
        .req    (req[IDX]),
        .try_in (try_w),
        .tok_in (tok_w),
        .o      (stage[j])
      );
    end
    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_merge
      assign grant[i] = stage[i].ok | stage[i+NUM_CELLS].ok;
    end
  endgenerate
endmodule

// File: rtl/token_ring_arbiter.sv
module token_ring_arbiter #(
  parameter int unsigned NUM_CELLS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CELLS-1:0] req,
  output logic [NUM_CELLS-1:0] grant
);
  localparam int unsigned WAIT_W = $clog2(NUM_CELLS + 1);

  logic [NUM_CELLS-1:0] token;
  logic [NUM_CELLS-1:0] grant_c;

  tr_token_ring #(.NUM_CELLS(NUM_CELLS)) u_token (
    .clk   (clk),
    .rst   (rst),
    .token (token)
  );

  tr_scan_chain #(.NUM_CELLS(NUM_CELLS)) u_scan (
    .req   (req),
    .token (token),
    .grant (grant_c)
  );

  always_ff @(posedge clk) begin
    if (rst) grant <= '0;
    else     grant <= grant_c;
  end

  // R2: grant output at most one-hot
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R3: no request yields no grant
  a_r3_idle: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |=> (grant == '0));

  // R4: a requesting token holder wins
  a_r4_holder: assert property (@(posedge clk) disable iff (rst)
    ((req & token) != '0) |=> (grant == $past(token)));

  // R5: any grant goes to a cell that was requesting
  a_r5_granted_requested: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> ((grant & $past(req)) != '0));

  // R8: bounded wait for a steady requester, tracked with counters
  generate
    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_wait
      logic [WAIT_W-1:0] wait_q;
      always_ff @(posedge clk) begin
        if (rst || !req[i] || grant_c[i]) wait_q <= '0;
        else                              wait_q <= wait_q + 1'b1;
      end
      a_r8_no_starve: assert property (@(posedge clk) disable iff (rst)
        wait_q < WAIT_W'(NUM_CELLS));
    end
  endgenerate
endmodule

// File: tb/token_ring_arbiter_bench.sv
`timescale 1ns/1ps
module token_ring_arbiter_bench;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic [N-1:0] grant;

  int checks = 0;
  int fails  = 0;
  int ptr    = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  token_ring_arbiter #(.NUM_CELLS(N)) u_token_ring_arbiter (
    .clk(clk), .rst(rst), .req(req), .grant(grant)
  );

  function automatic logic [N-1:0] pick(input logic [N-1:0] r, input int p);
    for (int k = 0; k < N; k++) begin
      if (r[(p + k) % N]) return (N'(1) << ((p + k) % N));
    end
    return '0;
  endfunction

  task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: grant=%b expected=%b", tag, act, exp);
    end
  endtask

  // drive at negedge, check just after the next edge
  task automatic step(input logic [N-1:0] r, input string tag);
    logic [N-1:0] exp;
    req = r;
    exp = pick(r, ptr);
    @(posedge clk); #1;
    check(grant, exp, tag);
    checks++;
    if ($countones(grant) > 1) begin
      fails++;
      $display("FAIL R2: grant=%b expected at most one bit", grant);
    end
    ptr = (ptr + 1) % N;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; req = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(grant, '0, "R1 grant during reset");
    rst = 1'b0; ptr = 0;
    step('1, "R1 first grant after reset at cell 0");
  endtask

  task automatic t_idle();
    for (int c = 0; c < 5; c++) step('0, "R3 idle gives no grant");
    step('1, "R6 token kept moving while idle");
  endtask

  task automatic t_holder();
    for (int c = 0; c < N; c++) step(N'(1) << ptr, "R4 holder alone granted");
    for (int c = 0; c < N; c++) step((N'(1) << ptr) | (N'(1) << ((ptr + 2) % N)), "R4 holder beats others");
  endtask

  task automatic t_scan();
    for (int c = 0; c < N; c++) step(N'(1) << ((ptr + N - 1) % N), "R5 wrap to cell before holder");
    for (int c = 0; c < N; c++) step(N'(1) << ((ptr + 2) % N) | N'(1) << ((ptr + 3) % N), "R5 nearest after holder");
    step(4'b0001, "R5 lone low cell");
    step(4'b1000, "R5 lone top cell");
    step(4'b0110, "R5 middle pair");
  endtask

  task automatic t_all_ones();
    logic [N-1:0] seen = '0;
    for (int c = 0; c < N; c++) begin
      step('1, "R6 all requests rotate");
      seen |= grant;
    end
    check(seen, '1, "R6 each cell granted once per lap");
  endtask

  task automatic t_registered();
    req = 4'b0000;
    @(posedge clk); #1; ptr = (ptr + 1) % N;
    @(negedge clk);
    req = 4'b1111; #1;
    check(grant, '0, "R7 request change between edges not visible");
    step(4'b1111, "R7 grant after edge");
  endtask

  task automatic t_fair();
    int gap = 0;
    int worst = 0;
    logic [N-1:0] pat;
    for (int c = 0; c < 4 * N; c++) begin
      pat = N'(c * 5 + 3) | 4'b0100;
      step(pat, "R8 steady requester mix");
      if (grant[2]) gap = 0; else gap++;
      if (gap > worst) worst = gap;
    end
    checks++;
    if (worst >= N) begin
      fails++;
      $display("FAIL R8: wait=%0d expected below %0d", worst, N);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_idle();
    t_holder();
    t_scan();
    t_all_ones();
    t_registered();
    t_fair();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule